// File: doc/BRIEF.md
# Flash Controller Command and Interrupt Register File

This block is the register front end of a NAND-style flash controller. A host reaches it through a simple 16-bit register port: a write strobe, a register index and the data, with read data returned combinationally for the index presented. The block holds six registers: a command register, two system configuration words, a controller status word, an interrupt status word and a start-buffer word. The start-buffer word selects which buffer an operation uses and how many sectors it covers.

When the host writes a recognised operation code, the block emits a one-cycle issue strobe to an external array engine. The strobe carries the code, the buffer address and the sector count. The engine later returns a completion pulse with an operation class and an optional error flag. The block folds that pulse into the interrupt and status words. It drives an interrupt pin whose polarity is set by a configuration bit, and a ready pin that the host controls by writing configuration word 1.

A command write is refused while the master interrupt flag is pending. The host acknowledges an event by AND-writing the interrupt word. Clearing the master flag this way also wipes the error bits.

Top module: `flash_cmd_regs`

## Requirements
- R1: After the asynchronous reset (power-on), the registers read as follows: configuration 1 is 0x40C0, configuration 2 is 0x0000, status is 0x0000, interrupt status is 0x8080, command is 0x0000 and start-buffer is 0x0000. The ready pin is 1. Register indices are: command 0, configuration 1 at 1, configuration 2 at 2, status 3, interrupt status 4, start-buffer 5.
- R2: A write of a recognised code to the command register while interrupt status bit 15 is clear stores the code. In the next cycle `cmd_valid_o` is high for exactly one cycle, with `cmd_code_o`, `cmd_buf_o` and `cmd_cnt_o` presenting the code, the buffer address and the sector count.
- R3: While interrupt status bit 15 is set, a write to the command register has no effect at all: no strobe, and the command readback is unchanged.
- R4: The recognised codes are 0x0000, 0x0013, 0x001A, 0x001B, 0x0023, 0x0027, 0x002A, 0x002C, 0x0030, 0x0065, 0x0071, 0x0080, 0x0094, 0x0095 and 0x00B0. Any other accepted code, apart from the reset codes of R11, is stored without a strobe and sets status bit 10 (command error) and interrupt status bit 15.
- R5: A write to interrupt status replaces it with the AND of the old value and the written value. If bit 15 is clear afterwards, status bits 13:10 are cleared as well. If bit 15 remains set, those bits are kept.
- R6: A completion pulse (`op_done_i`) sets interrupt status bit 15 and a class bit chosen by `op_kind_i`: load (0) sets bit 7, program (1) sets bit 6, erase (2) sets bit 5, and other (3) sets no class bit.
- R7: A completion pulse with `op_err_i` high also sets status bit 10. It additionally sets the class error bit: bit 13 for load, bit 12 for program and bit 11 for erase.
- R8: The interrupt pin `irq_o` equals interrupt status bit 15 XOR the inverse of configuration 1 bit 6, at all times.
- R9: Configuration 1 reads back with its low 5 bits forced to zero. Writing configuration 1 sets the ready pin to bit 7 of the written value. Configuration 2 reads back exactly as written.
- R10: In start-buffer, bits 11:8 hold the buffer address and bits 1:0 hold the sector count, with 0 meaning 4. The register reads back as the buffer address in bits 11:8 and the count minus one in bits 1:0. `cmd_cnt_o` gives the count as 1 to 4.
- R11: An accepted command write of 0x00F0 or 0x00F3 performs a warm reset. The registers take their R1 values except that interrupt status becomes 0x8010, the ready pin is 1, and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register index for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| op_done_i | input | 1 | Completion pulse from the array engine |
| op_kind_i | input | 2 | Class of the completed operation |
| op_err_i | input | 1 | Completion carried an error |
| cmd_valid_o | output | 1 | One-cycle command issue strobe |
| cmd_code_o | output | 16 | Command code |
| cmd_buf_o | output | 4 | Buffer address for the command |
| cmd_cnt_o | output | 3 | Sector count, 1 to 4 |
| irq_o | output | 1 | Interrupt pin, polarity from configuration 1 bit 6 |
| ready_o | output | 1 | Ready pin |

## Verification
The command path is exercised with a recognised program code, with an unrecognised code, with both reset codes, and with a write attempted while the master flag is pending. Together these separate issue, error flagging, warm reset and refusal. Completion pulses are applied for every operation class, with and without error, so that each class bit and error bit is shown to be distinct. Interrupt writes are tried with a mask that keeps bit 15 and with one that clears it, which tells error retention apart from error wiping. Both polarities of configuration 1 bit 6 are used to show how the pin follows the flag.

// File: rtl/flash_regs_pkg.sv
package flash_regs_pkg;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] RA_CMD   = 3'd0;
    localparam logic [ADDR_W-1:0] RA_CFG1  = 3'd1;
    localparam logic [ADDR_W-1:0] RA_CFG2  = 3'd2;
    localparam logic [ADDR_W-1:0] RA_STAT  = 3'd3;
    localparam logic [ADDR_W-1:0] RA_ISTAT = 3'd4;
    localparam logic [ADDR_W-1:0] RA_SBUF  = 3'd5;

    // interrupt status bit positions
    localparam int IB_MASTER = 15;
    localparam int IB_ERASE  = 5;
    localparam int IB_PROG   = 6;
    localparam int IB_LOAD   = 7;

    // controller status bit positions
    localparam int EB_CMD   = 10;
    localparam int EB_ERASE = 11;
    localparam int EB_PROG  = 12;
    localparam int EB_LOAD  = 13;

    localparam logic [REG_W-1:0] CFG1_DEFAULT = 16'h40C0;
    localparam logic [REG_W-1:0] ISTAT_COLD   = 16'h8080;
    localparam logic [REG_W-1:0] ISTAT_WARM   = 16'h8010;
    localparam logic [REG_W-1:0] CFG1_RD_MASK = 16'hFFE0;

    typedef enum logic [1:0] {
        OPK_LOAD  = 2'd0,
        OPK_PROG  = 2'd1,
        OPK_ERASE = 2'd2,
        OPK_OTHER = 2'd3
    } op_kind_e;
endpackage

// File: rtl/fc_cmd_decode.sv
module fc_cmd_decode
    import flash_regs_pkg::*;
(
    input  logic [REG_W-1:0] code,
    output logic             known,
    output logic             soft_reset
);
    always_comb begin
        known      = 1'b0;
        soft_reset = 1'b0;
        case (code)
            16'h0000, 16'h0013, 16'h001A, 16'h001B,
            16'h0023, 16'h0027, 16'h002A, 16'h002C,
            16'h0030, 16'h0065, 16'h0071, 16'h0080,
            16'h0094, 16'h0095, 16'h00B0: known = 1'b1;
            16'h00F0, 16'h00F3:           soft_reset = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/fc_irq_pin.sv
module fc_irq_pin (
    input  logic master,
    input  logic pol_bit,
    output logic irq
);
    // pol_bit = 1: pin follows the flag; pol_bit = 0: pin is inverted
    assign irq = master ^ ~pol_bit;
endmodule

// File: rtl/fc_read_mux.sv
module fc_read_mux
    import flash_regs_pkg::*;
#(
    parameter int BUF_W = 4,
    parameter int CNT_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  cmd,
    input  logic [REG_W-1:0]  cfg1,
    input  logic [REG_W-1:0]  cfg2,
    input  logic [REG_W-1:0]  stat,
    input  logic [REG_W-1:0]  istat,
    input  logic [BUF_W-1:0]  bufa,
    input  logic [CNT_W-1:0]  cnt_raw,
    output logic [REG_W-1:0]  rdata
);
    localparam int BUF_LSB = 8;
    logic [CNT_W-1:0] cnt_m1;

    assign cnt_m1 = cnt_raw - 1'b1;

    always_comb begin
        unique case (addr)
            RA_CMD:   rdata = cmd;
            RA_CFG1:  rdata = cfg1 & CFG1_RD_MASK;
            RA_CFG2:  rdata = cfg2;
            RA_STAT:  rdata = stat;
            RA_ISTAT: rdata = istat;
            RA_SBUF:  rdata = (REG_W'(bufa) << BUF_LSB) | REG_W'(cnt_m1);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
    import flash_regs_pkg::*;
#(
    parameter int BUF_W = 4,
    parameter int CNT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              op_done_i,
    input  logic [1:0]        op_kind_i,
    input  logic              op_err_i,
    output logic              cmd_valid_o,
    output logic [REG_W-1:0]  cmd_code_o,
    output logic [BUF_W-1:0]  cmd_buf_o,
    output logic [CNT_W:0]    cmd_cnt_o,
    output logic              irq_o,
    output logic              ready_o
);
    localparam int BUF_LSB = 8;

    typedef struct packed {
        logic [REG_W-1:0] cmd;
        logic [REG_W-1:0] cfg1;
        logic [REG_W-1:0] cfg2;
        logic [REG_W-1:0] stat;
        logic [REG_W-1:0] istat;
        logic [BUF_W-1:0] bufa;
        logic [CNT_W-1:0] cnt;
        logic             rdy;
        logic             strobe;
    } state_t;

    state_t st_d, st_q;

    function automatic state_t reset_value(input logic [REG_W-1:0] ist);
        state_t r;
        r.cmd    = '0;
        r.cfg1   = CFG1_DEFAULT;
        r.cfg2   = '0;
        r.stat   = '0;
        r.istat  = ist;
        r.bufa   = '0;
        r.cnt    = CNT_W'(1);
        r.rdy    = 1'b1;
        r.strobe = 1'b0;
        return r;
    endfunction

    logic code_known, code_reset;
    logic [REG_W-1:0] istat_w, stat_w, cfg1_w;

    assign istat_w = st_q.istat;
    assign stat_w  = st_q.stat;
    assign cfg1_w  = st_q.cfg1;

    fc_cmd_decode u_dec (
        .code       (wdata),
        .known      (code_known),
        .soft_reset (code_reset)
    );

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;

        if (wr_en) begin
            unique case (addr)
                RA_CMD: begin
                    if (!st_q.istat[IB_MASTER]) begin
                        if (code_reset) begin
                            st_d = reset_value(ISTAT_WARM);
                        end else begin
                            st_d.cmd = wdata;
                            if (code_known) begin
                                st_d.strobe = 1'b1;
                            end else begin
                                st_d.stat[EB_CMD]     = 1'b1;
                                st_d.istat[IB_MASTER] = 1'b1;
                            end
                        end
                    end
                end
                RA_CFG1: begin
                    st_d.cfg1 = wdata;
                    st_d.rdy  = wdata[7];
                end
                RA_CFG2:  st_d.cfg2 = wdata;
                RA_ISTAT: begin
                    st_d.istat = st_q.istat & wdata;
                    if (!st_d.istat[IB_MASTER])
                        st_d.stat[EB_LOAD:EB_CMD] = '0;
                end
                RA_SBUF: begin
                    st_d.bufa = wdata[BUF_LSB +: BUF_W];
                    st_d.cnt  = wdata[CNT_W-1:0];
                end
                default: ;
            endcase
        end

        if (op_done_i) begin
            st_d.istat[IB_MASTER] = 1'b1;
            unique case (op_kind_e'(op_kind_i))
                OPK_LOAD:  st_d.istat[IB_LOAD]  = 1'b1;
                OPK_PROG:  st_d.istat[IB_PROG]  = 1'b1;
                OPK_ERASE: st_d.istat[IB_ERASE] = 1'b1;
                default: ;
            endcase
            if (op_err_i) begin
                st_d.stat[EB_CMD] = 1'b1;
                unique case (op_kind_e'(op_kind_i))
                    OPK_LOAD:  st_d.stat[EB_LOAD]  = 1'b1;
                    OPK_PROG:  st_d.stat[EB_PROG]  = 1'b1;
                    OPK_ERASE: st_d.stat[EB_ERASE] = 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_value(ISTAT_COLD);
        else        st_q <= st_d;
    end

    fc_irq_pin u_irq (
        .master  (istat_w[IB_MASTER]),
        .pol_bit (cfg1_w[6]),
        .irq     (irq_o)
    );

    fc_read_mux #(.BUF_W(BUF_W), .CNT_W(CNT_W)) u_rd (
        .addr    (addr),
        .cmd     (st_q.cmd),
        .cfg1    (cfg1_w),
        .cfg2    (st_q.cfg2),
        .stat    (stat_w),
        .istat   (istat_w),
        .bufa    (st_q.bufa),
        .cnt_raw (st_q.cnt),
        .rdata   (rdata)
    );

    assign cmd_valid_o = st_q.strobe;
    assign cmd_code_o  = st_q.cmd;
    assign cmd_buf_o   = st_q.bufa;
    assign cmd_cnt_o   = {(st_q.cnt == '0), st_q.cnt};
    assign ready_o     = st_q.rdy;
endmodule

// File: rtl/fc_regs_checker.sv
module fc_regs_checker
    import flash_regs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [REG_W-1:0]  wdata,
    input logic              op_done_i,
    input logic              op_err_i,
    input logic [REG_W-1:0]  istat,
    input logic [REG_W-1:0]  stat,
    input logic [REG_W-1:0]  cfg1,
    input logic              cmd_valid_o,
    input logic [REG_W-1:0]  cmd_code_o,
    input logic              irq_o
);
    p_strobe_from_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> $past(wr_en && addr == RA_CMD));

    p_cmd_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_CMD && istat[IB_MASTER]) |=> (!cmd_valid_o && $stable(cmd_code_o)));

    p_err_wipe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_ISTAT && !wdata[IB_MASTER] && !op_done_i) |=> (stat[EB_LOAD:EB_CMD] == 4'b0000));

    p_done_master_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_done_i |=> istat[IB_MASTER]);

    p_err_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done_i && op_err_i) |=> stat[EB_CMD]);

    p_irq_polarity_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (istat[IB_MASTER] ^ !cfg1[6]));
endmodule

bind flash_cmd_regs fc_regs_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .op_done_i   (op_done_i),
    .op_err_i    (op_err_i),
    .istat       (istat_w),
    .stat        (stat_w),
    .cfg1        (cfg1_w),
    .cmd_valid_o (cmd_valid_o),
    .cmd_code_o  (cmd_code_o),
    .irq_o       (irq_o)
);

// File: tb/flash_cmd_regs_tb.sv
module flash_cmd_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        op_done = 1'b0;
    logic [1:0]  op_kind = '0;
    logic        op_err = 1'b0;
    logic        cmd_valid;
    logic [15:0] cmd_code;
    logic [3:0]  cmd_buf;
    logic [2:0]  cmd_cnt;
    logic        irq, ready;

    int checks = 0;
    int errors = 0;
    bit done_run = 1'b0;

    // behavioural reference state
    int m_cmd, m_cfg1, m_cfg2, m_stat, m_istat, m_bufa, m_cnt;
    bit m_rdy, m_strobe;

    always #5 clk = ~clk;

    flash_cmd_regs u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .op_done_i(op_done), .op_kind_i(op_kind), .op_err_i(op_err),
        .cmd_valid_o(cmd_valid), .cmd_code_o(cmd_code), .cmd_buf_o(cmd_buf),
        .cmd_cnt_o(cmd_cnt), .irq_o(irq), .ready_o(ready)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic model_reset(input int ist);
        m_cmd = 0; m_cfg1 = 'h40C0; m_cfg2 = 0; m_stat = 0; m_istat = ist;
        m_bufa = 0; m_cnt = 1; m_rdy = 1; m_strobe = 0;
    endtask

    function automatic bit known_code(input int c);
        int list[15] = '{'h00, 'h13, 'h1A, 'h1B, 'h23, 'h27, 'h2A, 'h2C,
                         'h30, 'h65, 'h71, 'h80, 'h94, 'h95, 'hB0};
        foreach (list[i]) if (list[i] == c) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_step(input bit we, input int a, input int d,
                              input bit dn, input int k, input bit er);
        m_strobe = 0;
        if (we) begin
            if (a == 0) begin
                if ((m_istat & 'h8000) == 0) begin
                    if (d == 'hF0 || d == 'hF3) model_reset('h8010);
                    else begin
                        m_cmd = d;
                        if (known_code(d)) m_strobe = 1;
                        else begin m_stat |= 'h0400; m_istat |= 'h8000; end
                    end
                end
            end else if (a == 1) begin
                m_cfg1 = d; m_rdy = (d >> 7) & 1;
            end else if (a == 2) m_cfg2 = d;
            else if (a == 4) begin
                m_istat &= d;
                if ((m_istat & 'h8000) == 0) m_stat &= ~'h3C00;
            end else if (a == 5) begin
                m_bufa = (d >> 8) & 'hF; m_cnt = d & 3;
            end
        end
        if (dn) begin
            m_istat |= 'h8000;
            if (k == 0) m_istat |= 'h80;
            if (k == 1) m_istat |= 'h40;
            if (k == 2) m_istat |= 'h20;
            if (er) begin
                m_stat |= 'h0400;
                if (k == 0) m_stat |= 'h2000;
                if (k == 1) m_stat |= 'h1000;
                if (k == 2) m_stat |= 'h0800;
            end
        end
    endtask

    function automatic int model_read(input int a);
        case (a)
            0: return m_cmd;
            1: return m_cfg1 & 'hFFE0;
            2: return m_cfg2;
            3: return m_stat;
            4: return m_istat;
            5: return (m_bufa << 8) | ((m_cnt + 3) & 3);
            default: return 0;
        endcase
    endfunction

    task automatic compare_pins();
        int irq_exp = ((m_istat >> 15) & 1) ^ (((m_cfg1 >> 6) & 1) ^ 1);
        check("R2 strobe", cmd_valid, m_strobe);
        check("R2 code", cmd_code, m_cmd);
        check("R10 buffer", cmd_buf, m_bufa);
        check("R10 count", cmd_cnt, (m_cnt == 0) ? 4 : m_cnt);
        check("R8 irq pin", irq, irq_exp);
        check("R9 ready pin", ready, m_rdy);
    endtask

    task automatic tick(input bit we, input int a, input int d,
                        input bit dn, input int k, input bit er);
        @(negedge clk);
        wr_en = we; addr = 3'(a); wdata = 16'(d);
        op_done = dn; op_kind = 2'(k); op_err = er;
        @(posedge clk);
        model_step(we, a, d, dn, k, er);
        #1 compare_pins();
    endtask

    task automatic wr(input int a, input int d);
        tick(1'b1, a, d, 1'b0, 0, 1'b0);
    endtask

    task automatic done_ev(input int k, input bit er);
        tick(1'b0, 0, 0, 1'b1, k, er);
    endtask

    task automatic rd(input string req, input int a);
        @(negedge clk);
        wr_en = 0; op_done = 0; op_err = 0; addr = 3'(a);
        #1 check(req, rdata, model_read(a));
        @(posedge clk);
        model_step(1'b0, 0, 0, 1'b0, 0, 1'b0);
        #1 compare_pins();
    endtask

    task automatic cold_reset();
        @(negedge clk);
        wr_en = 0; op_done = 0; op_err = 0;
        rst_n = 0;
        model_reset('h8080);
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1;
        @(posedge clk);
        model_step(1'b0, 0, 0, 1'b0, 0, 1'b0);
        #1 compare_pins();
    endtask

    initial begin
        #2_000_000;
        if (!done_run) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cold_reset();
        // R1 reset values
        for (int a = 0; a < 6; a++) rd("R1 reset readback", a);
        check("R1 ready after reset", ready, 1);

        // R3 command refused while flag pending
        wr(0, 'h0080);
        rd("R3 command unchanged", 0);

        // R5 clear everything
        wr(4, 'h0000);
        rd("R5 istat cleared", 4);

        // R10 start-buffer
        wr(5, 'h0A02);
        rd("R10 readback count 2", 5);
        wr(5, 'h0300);
        rd("R10 readback count 4", 5);

        // R2 accepted program command
        wr(0, 'h0080);
        check("R2 strobe seen", cmd_valid, 1);
        rd("R2 command readback", 0);

        // R6 / R7 completions
        done_ev(1, 1'b0);
        rd("R6 program done", 4);
        wr(4, 'h8000);
        rd("R5 keep master", 4);
        done_ev(0, 1'b1);
        rd("R7 load error", 3);
        rd("R6 load done", 4);
        wr(4, 'hFFFF);
        rd("R5 errors kept while master set", 3);
        wr(4, 'h0000);
        rd("R5 errors wiped", 3);
        done_ev(2, 1'b1);
        rd("R6 erase done", 4);
        rd("R7 erase error", 3);
        wr(4, 'h0000);
        done_ev(3, 1'b1);
        rd("R6 other class", 4);
        rd("R7 other class error", 3);
        wr(4, 'h0000);
        rd("R5 wiped again", 3);

        // R4 unknown code
        wr(0, 'h0042);
        check("R4 no strobe", cmd_valid, 0);
        rd("R4 status error", 3);
        rd("R4 master set", 4);

        // R8 / R9 configuration and polarity
        wr(1, 'h0017);
        rd("R9 cfg1 masked", 1);
        check("R8 inverted polarity", irq, 0);
        wr(1, 'h00D5);
        rd("R9 cfg1 masked high", 1);
        check("R9 ready follows bit 7", ready, 1);
        wr(2, 'h1234);
        rd("R9 cfg2 readback", 2);
        wr(4, 'h0000);
        check("R8 irq low with flag clear", irq, 0);
        wr(1, 'h0040);
        check("R8 follow polarity", irq, 0);
        check("R9 ready low", ready, 0);

        // R11 warm reset commands
        wr(0, 'h00F0);
        check("R11 no strobe", cmd_valid, 0);
        for (int a = 0; a < 6; a++) rd("R11 warm readback", a);
        wr(4, 'h0000);
        wr(5, 'h0F01);
        wr(0, 'h00F3);
        rd("R11 second reset code istat", 4);
        rd("R11 start-buffer restored", 5);

        // R1 cold reset again after activity
        wr(4, 'h0000);
        wr(2, 'hBEEF);
        cold_reset();
        rd("R1 cold istat", 4);
        rd("R1 cold cfg2", 2);

        done_run = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule